// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

This bridge sits between a single-master 32-bit word bus and a word-wide SRAM. It gives software single-bit access to memory words without separate storage. A plain region of 1 MiB starts at 0x2000_0000. A 32 MiB alias window starts at 0x2200_0000, and each word in that window stands for exactly one bit of the plain region. Accesses to the plain region go straight to the SRAM. Accesses to the alias window become single-bit operations on the word that holds the target bit.

An alias read fetches the target word and returns the chosen bit as 0 or 1. An alias write is a locked read-modify-write that changes only that bit. The bridge holds a bus-lock output high from the read through the write, so no other master can touch the word between the two. Any address outside both regions completes at once with an error response.

The bus master holds `bus_req_i`, `bus_we_i`, `bus_addr_i` and `bus_wdata_i` steady until `bus_ready_o` pulses for one cycle. The SRAM accepts one request per cycle. Read data appears on `mem_rdata_i` one cycle after a read request.

Top module: `bitband_bridge`

## Requirements
- R1: A plain-region read (address bits 31:20 equal 0x200) issues one SRAM read of word index addr[19:2] and returns that word on `bus_rdata_o` with `bus_ready_o` in the cycle after the request is seen.
- R2: A plain-region write issues exactly one SRAM write of `bus_wdata_i` to word index addr[19:2], completes in the cycle after the request, and never raises `lock_o`.
- R3: An alias address (bits 31:25 equal 0x11) selects SRAM word (addr − 0x2200_0000) >> 7, and selects bit addr[6:2] within that word.
- R4: An alias read returns the selected bit in bit 0 and zeros in bits 31:1. It makes one SRAM read and no SRAM write.
- R5: An alias write reads the target word and then writes the same word back. Only the selected bit changes, and it takes the value of `bus_wdata_i[0]`. All other bits keep their old values.
- R6: `lock_o` is high for exactly the two cycles of the alias read-modify-write: the read cycle and the write cycle. It is low at all other times.
- R7: Plain and alias accesses reach the same storage. A bit written through the alias window shows up in a plain read, and a plain write shows up in alias reads.
- R8: An address outside both regions completes in the cycle after the request, with `bus_err_o` high, `bus_rdata_o` zero, and no SRAM access.
- R9: `bus_ready_o` is a one-cycle pulse. For an alias write it comes three cycles after the request is seen, which is one cycle after the SRAM write.
- R10: While `rst_ni` is low, `lock_o` and `bus_ready_o` are low. A reset in the middle of an alias write abandons the write before any SRAM write is made.
- R11: At the top edges of the regions, alias address 0x23FF_FFFC maps to word 0x3FFFF bit 31. Addresses 0x2010_0000 and 0x2400_0000 give an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request, held until ready |
| bus_we_i | input | 1 | Bus write enable |
| bus_addr_i | input | 32 | Bus byte address |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, valid with ready |
| bus_ready_o | output | 1 | Transfer complete, one-cycle pulse |
| bus_err_o | output | 1 | Error response, valid with ready |
| mem_req_o | output | 1 | SRAM request |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | 18 | SRAM word index |
| mem_wdata_o | output | 32 | SRAM write data |
| mem_rdata_i | input | 32 | SRAM read data, one cycle after a read |
| lock_o | output | 1 | Bus lock held during the alias read-modify-write |

## Verification
The hardest case to reach from the ports is a reset that arrives between the locked read and the locked write. If the bridge mishandled it, it could write back a stale or half-merged word, or leave the lock stuck high. The bench starts an alias write and waits until it sees the lock go high, which marks the read cycle. It then pulls reset at once. After that it checks that the lock has dropped, that the SRAM saw no write, and that a plain read returns the word unchanged. The boundary words at the top of each region are reached with alias addresses built from the decode formula.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int DW    = 32;
  localparam int BIT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY_WRITE,
    ST_DONE
  } bb_state_e;

  typedef enum logic [1:0] {
    ACC_PLAIN,
    ACC_ALIAS,
    ACC_NONE
  } acc_kind_e;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter logic [31:0] PLAIN_BASE = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          REGION_AW  = 20,
  localparam int         WORD_AW    = REGION_AW - 2,
  localparam int         ALIAS_AW   = REGION_AW + 5
) (
  input  logic [31:0]        addr_i,
  output acc_kind_e          kind_o,
  output logic [WORD_AW-1:0] word_o,
  output logic [BIT_W-1:0]   bit_o
);
  logic plain_hit, alias_hit;
  logic [1:0] unused_low;

  assign unused_low = addr_i[1:0];
  assign plain_hit  = addr_i[31:REGION_AW] == PLAIN_BASE[31:REGION_AW];
  assign alias_hit  = addr_i[31:ALIAS_AW]  == ALIAS_BASE[31:ALIAS_AW];

  always_comb begin
    if (plain_hit) begin
      kind_o = ACC_PLAIN;
      word_o = addr_i[REGION_AW-1:2];
    end else if (alias_hit) begin
      kind_o = ACC_ALIAS;
      word_o = addr_i[ALIAS_AW-1:7];
    end else begin
      kind_o = ACC_NONE;
      word_o = '0;
    end
  end

  assign bit_o = addr_i[6:2];
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [DW-1:0]    word_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  output logic             bit_o,
  output logic [DW-1:0]    merged_o
);
  assign bit_o = word_i[bit_idx_i];

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign merged_o[g] = (bit_idx_i == BIT_W'(g)) ? bit_val_i : word_i[g];
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int WORD_AW = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  acc_kind_e          kind_i,
  input  logic [WORD_AW-1:0] word_i,
  input  logic [BIT_W-1:0]   bit_i,
  input  logic               bit_val_i,
  output bb_state_e          state_o,
  output acc_kind_e          kind_o,
  output logic               we_o,
  output logic [WORD_AW-1:0] word_o,
  output logic [BIT_W-1:0]   bit_o,
  output logic               bit_val_o,
  output logic               err_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               lock_o,
  output logic               ready_o
);
  bb_state_e state_q, state_d;
  logic accept;

  assign accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d   = state_q;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        unique case (kind_i)
          ACC_PLAIN: begin
            mem_req_o = 1'b1;
            mem_we_o  = we_i;
            state_d   = ST_DONE;
          end
          ACC_ALIAS: begin
            if (we_i) begin
              state_d = ST_READ;
            end else begin
              mem_req_o = 1'b1;
              state_d   = ST_DONE;
            end
          end
          default: state_d = ST_DONE;
        endcase
      end
      ST_READ: begin
        mem_req_o = 1'b1;
        state_d   = ST_MODIFY_WRITE;
      end
      ST_MODIFY_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        state_d   = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_o    <= ACC_NONE;
      we_o      <= 1'b0;
      word_o    <= '0;
      bit_o     <= '0;
      bit_val_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_o    <= kind_i;
        we_o      <= we_i;
        word_o    <= word_i;
        bit_o     <= bit_i;
        bit_val_o <= bit_val_i;
        err_o     <= (kind_i == ACC_NONE);
      end
    end
  end

  assign state_o = state_q;
  assign lock_o  = (state_q == ST_READ) || (state_q == ST_MODIFY_WRITE);
  assign ready_o = (state_q == ST_DONE);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] PLAIN_BASE = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          REGION_AW  = 20,
  localparam int         WORD_AW    = REGION_AW - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [31:0]        bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               bus_ready_o,
  output logic               bus_err_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [WORD_AW-1:0] mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               lock_o
);
  acc_kind_e          dec_kind, kind_q;
  logic [WORD_AW-1:0] dec_word, word_q;
  logic [BIT_W-1:0]   dec_bit, bit_q;
  logic               we_q, bit_val_q, err_q;
  bb_state_e          state;
  logic               sel_bit;
  logic [DW-1:0]      merged;

  bb_decode #(
    .PLAIN_BASE(PLAIN_BASE),
    .ALIAS_BASE(ALIAS_BASE),
    .REGION_AW (REGION_AW)
  ) i_decode (
    .addr_i(bus_addr_i),
    .kind_o(dec_kind),
    .word_o(dec_word),
    .bit_o (dec_bit)
  );

  bb_seq #(.WORD_AW(WORD_AW)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .kind_i   (dec_kind),
    .word_i   (dec_word),
    .bit_i    (dec_bit),
    .bit_val_i(bus_wdata_i[0]),
    .state_o  (state),
    .kind_o   (kind_q),
    .we_o     (we_q),
    .word_o   (word_q),
    .bit_o    (bit_q),
    .bit_val_o(bit_val_q),
    .err_o    (err_q),
    .mem_req_o(mem_req_o),
    .mem_we_o (mem_we_o),
    .lock_o   (lock_o),
    .ready_o  (bus_ready_o)
  );

  bb_bit_merge i_merge (
    .word_i   (mem_rdata_i),
    .bit_idx_i(bit_q),
    .bit_val_i(bit_val_q),
    .bit_o    (sel_bit),
    .merged_o (merged)
  );

  // IDLE issues from the live decode; the locked phases replay the latched word
  assign mem_addr_o  = (state == ST_IDLE) ? dec_word : word_q;
  assign mem_wdata_o = (state == ST_MODIFY_WRITE) ? merged : bus_wdata_i;
  assign bus_err_o   = bus_ready_o && err_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_ready_o && !err_q && !we_q) begin
      if (kind_q == ACC_ALIAS) bus_rdata_o = {{(DW-1){1'b0}}, sel_bit};
      else                     bus_rdata_o = mem_rdata_i;
    end
  end
endmodule

// File: rtl/bb_checker.sv
module bb_checker
  import bb_pkg::*;
#(
  parameter int WORD_AW = 18
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_ready_o,
  input logic               bus_err_o,
  input logic [DW-1:0]      bus_rdata_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [WORD_AW-1:0] mem_addr_o,
  input logic [DW-1:0]      mem_wdata_o,
  input logic [DW-1:0]      mem_rdata_i,
  input logic               lock_o,
  input acc_kind_e          kind_q,
  input logic               we_q,
  input logic [BIT_W-1:0]   bit_q
);
  logic [DW-1:0] keep_mask;
  assign keep_mask = ~(DW'(1) << bit_q);

  AST_ALIAS_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o && kind_q == ACC_ALIAS && !we_q |-> bus_rdata_o[DW-1:1] == '0); // R4
  AST_LOCK_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && mem_req_o && !mem_we_o |=> lock_o && mem_req_o && mem_we_o); // R6
  AST_RMW_SAME_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && mem_req_o && !mem_we_o |=> mem_addr_o == $past(mem_addr_o)); // R5
  AST_RMW_KEEP_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && mem_we_o |-> (mem_wdata_o & keep_mask) == (mem_rdata_i & keep_mask)); // R5
  AST_ERR_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> bus_ready_o && !$past(mem_req_o) && bus_rdata_o == '0); // R8
  AST_UNLOCKED_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !lock_o |=> bus_ready_o); // R2
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o |=> !bus_ready_o); // R9
  AST_LOCK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && mem_we_o |=> !lock_o && bus_ready_o); // R9

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (!lock_o && !bus_ready_o); // R10
  end
endmodule

bind bitband_bridge bb_checker #(.WORD_AW(WORD_AW)) i_bb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_ready_o(bus_ready_o),
  .bus_err_o  (bus_err_o),
  .bus_rdata_o(bus_rdata_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i),
  .lock_o     (lock_o),
  .kind_q     (kind_q),
  .we_q       (we_q),
  .bit_q      (bit_q)
);

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata, mem_wdata;
  logic        ready, err, mem_req, mem_we, lock;
  logic [17:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [logic [17:0]];
  int n_wr = 0, n_rd = 0, n_lock = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bitband_bridge i_bitband_bridge (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_ready_o(ready), .bus_err_o(err), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .lock_o(lock)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    if (rst_n) begin
      if (mem_req && mem_we)  n_wr++;
      if (mem_req && !mem_we) n_rd++;
      if (lock)               n_lock++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic er, output int cyc);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ready && cyc < 20);
    rd = rdata; er = err;
    req = 1'b0;
  endtask

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        exp_err;
    logic [1:0]  exp_cyc;
    logic [1:0]  exp_lock;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h2000_0000, 32'hA5A5_0F0F, 32'h0,          1'b0, 2'd1, 2'd0}, // R2
    '{1'b0, 32'h2000_0000, 32'h0,         32'hA5A5_0F0F, 1'b0, 2'd1, 2'd0}, // R1
    '{1'b0, 32'h2200_0000, 32'h0,         32'h1,         1'b0, 2'd1, 2'd0}, // R4 R7 word0 bit0
    '{1'b0, 32'h2200_0010, 32'h0,         32'h0,         1'b0, 2'd1, 2'd0}, // R3 R4 bit4
    '{1'b1, 32'h2200_0010, 32'hFFFF_FFFF, 32'h0,         1'b0, 2'd3, 2'd2}, // R5 set bit4
    '{1'b0, 32'h2000_0000, 32'h0,         32'hA5A5_0F1F, 1'b0, 2'd1, 2'd0}, // R7
    '{1'b1, 32'h2200_007C, 32'hFFFF_FFFE, 32'h0,         1'b0, 2'd3, 2'd2}, // R5 clear bit31 from data bit0
    '{1'b0, 32'h2000_0000, 32'h0,         32'h25A5_0F1F, 1'b0, 2'd1, 2'd0}, // R5 R7
    '{1'b1, 32'h2000_0004, 32'h0,         32'h0,         1'b0, 2'd1, 2'd0}, // R2
    '{1'b1, 32'h2200_009C, 32'h1,         32'h0,         1'b0, 2'd3, 2'd2}, // R3 word1 bit7
    '{1'b0, 32'h2000_0004, 32'h0,         32'h0000_0080, 1'b0, 2'd1, 2'd0}, // R3 R7
    '{1'b0, 32'h2200_009C, 32'h0,         32'h1,         1'b0, 2'd1, 2'd0}, // R4
    '{1'b0, 32'h3000_0000, 32'h0,         32'h0,         1'b1, 2'd1, 2'd0}, // R8
    '{1'b1, 32'h2400_0000, 32'hFFFF_FFFF, 32'h0,         1'b1, 2'd1, 2'd0}, // R8 R11
    '{1'b0, 32'h2010_0000, 32'h0,         32'h0,         1'b1, 2'd1, 2'd0}, // R8 R11
    '{1'b1, 32'h200F_FFFC, 32'h1234_5678, 32'h0,         1'b0, 2'd1, 2'd0}, // R11 last word
    '{1'b1, 32'h23FF_FFFC, 32'h1,         32'h0,         1'b0, 2'd3, 2'd2}, // R11 last bit
    '{1'b0, 32'h200F_FFFC, 32'h0,         32'h9234_5678, 1'b0, 2'd1, 2'd0}, // R11 R7
    '{1'b0, 32'h23FF_FFE4, 32'h0,         32'h1,         1'b0, 2'd1, 2'd0}  // R11 bit25
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int cyc, w0, r0, l0;

    repeat (3) @(negedge clk);
    chk(!lock && !ready, "R10 outputs in reset", {30'b0, lock, ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!lock && !ready && !mem_req, "R10 idle after reset", {29'b0, lock, ready, mem_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      w0 = n_wr; r0 = n_rd; l0 = n_lock;
      xfer(VECS[i].w, VECS[i].a, VECS[i].d, rd, er, cyc);
      chk(cyc == int'(VECS[i].exp_cyc), "R9 cycles to ready", cyc, VECS[i].exp_cyc);
      chk(er == VECS[i].exp_err, "R8 error flag", er, VECS[i].exp_err);
      if (!VECS[i].w || VECS[i].exp_err)
        chk(rd == VECS[i].exp, "R1/R4 read data", rd, VECS[i].exp);
      chk(n_lock - l0 == int'(VECS[i].exp_lock), "R6 lock cycles", n_lock - l0, VECS[i].exp_lock);
      chk(n_wr - w0 == ((VECS[i].w && !VECS[i].exp_err) ? 1 : 0), "R2/R5 SRAM writes",
          n_wr - w0, (VECS[i].w && !VECS[i].exp_err) ? 1 : 0);
      if (VECS[i].exp_err)
        chk(n_rd == r0, "R8 no SRAM read", n_rd - r0, 0);
      if (!VECS[i].w && !VECS[i].exp_err)
        chk(n_rd - r0 == 1, "R1/R4 one SRAM read", n_rd - r0, 1);
    end

    // R10: reset during the locked read phase of an alias write
    w0 = n_wr;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 32'h2200_0000; wdata = 32'h0;
    @(negedge clk);
    chk(lock == 1'b1, "R6 lock in read phase", lock, 1);
    rst_n = 1'b0; req = 1'b0;
    #1;
    chk(lock == 1'b0 && ready == 1'b0, "R10 lock drops on reset", {30'b0, lock, ready}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(n_wr == w0, "R10 no write after abort", n_wr - w0, 0);
    xfer(1'b0, 32'h2000_0000, 32'h0, rd, er, cyc);
    chk(rd == 32'h25A5_0F1F, "R10 word intact", rd, 32'h25A5_0F1F);

    // R3: low address bits do not move the selected bit
    xfer(1'b0, 32'h2200_0013, 32'h0, rd, er, cyc);
    chk(rd == 32'h1, "R3 bit4 with low bits set", rd, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule